// File: doc/BRIEF.md
# Inverted Page Table Search Unit

This block translates a logical address made of a process identifier, a virtual page number and a page offset into a physical address. It holds a table with exactly one entry per physical frame. Each entry carries a page number, a process identifier, a control field and a chain link. Translation is a search: the unit looks for the entry whose process identifier and page number both equal the request's. The position of that entry in the table is the frame number. The frame number is then placed above the request's offset to form the physical address. No frame number is stored in the entry.

After a request is accepted, the unit walks the table from entry 0 upward, examining one entry per clock cycle. It stops at the first match. If the last entry does not match either, it reports a miss. Software fills the table through a write port and can inspect any entry through a combinational read port. Writes are refused while a search runs, so every entry a search examines stays fixed for the length of that search.

Top module: `ipt_search_unit`

## Requirements
- R1: After reset, `req_ready_o` and `wr_ready_o` are 1 and `rsp_valid_o` is 0. Every entry reads back as all zeros, so every entry is invalid.
- R2: An entry matches only if bit 0 of its control field (the valid bit) is 1 and both its process ID and its page number equal the request's. An entry where only one of the two fields agrees does not match.
- R3: On a hit, `rsp_paddr_o` holds the matching entry index in bits [PADDR_W-1:OFF_W] and the request offset in bits [OFF_W-1:0].
- R4: Entries are examined from index 0 upward, one per cycle, and the lowest matching index wins. For a hit at index i, `rsp_valid_o` rises i+1 clock edges after the edge that accepted the request.
- R5: When no entry matches, `rsp_valid_o` rises NUM_FRAMES edges after the accepting edge, with `rsp_hit_o`=0 and `rsp_paddr_o`=0.
- R6: A request is accepted at an edge where `req_valid_i` and `req_ready_o` are both 1. `req_ready_o` is 0 from that edge until the edge that raises `rsp_valid_o`, and request inputs are ignored in that interval.
- R7: A write with `wr_en_i`=1 and `wr_ready_o`=1 updates entry `wr_idx_i` at that edge. A search accepted at the same edge sees the new contents. `wr_ready_o` is 0 during a search, and a write presented then leaves the table unchanged, as seen on the read port.
- R8: `rsp_valid_o` is a one-cycle pulse. A new request can be accepted at the edge right after the pulse, which allows searches to run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Unit idle, request can be taken |
| req_pid_i | input | PID_W | Request process ID |
| req_vpn_i | input | VPN_W | Request virtual page number |
| req_off_i | input | OFF_W | Request page offset |
| wr_en_i | input | 1 | Table write strobe |
| wr_ready_o | output | 1 | Table write accepted this cycle |
| wr_idx_i | input | FRAME_W | Entry to write |
| wr_pid_i | input | PID_W | Process ID to store |
| wr_vpn_i | input | VPN_W | Page number to store |
| wr_ctrl_i | input | CTRL_W | Control field to store, bit 0 = valid |
| wr_link_i | input | FRAME_W | Chain link to store |
| rd_idx_i | input | FRAME_W | Entry to read back |
| rd_pid_o | output | PID_W | Read-back process ID |
| rd_vpn_o | output | VPN_W | Read-back page number |
| rd_ctrl_o | output | CTRL_W | Read-back control field |
| rd_link_o | output | FRAME_W | Read-back chain link |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_hit_o | output | 1 | 1 = translation found, 0 = miss |
| rsp_paddr_o | output | PADDR_W | Physical address, zero on a miss |

## Verification
The assertions are evaluated on every cycle. They check that accepting a request drops `req_ready_o`, that the response is a single-cycle pulse, and that a miss carries a zero address. They also check that the frame field of a hit equals the number of edges since acceptance minus one, that a miss arrives after exactly NUM_FRAMES edges, that the offset bits are the accepted ones, and that a refused write leaves the read port steady. Only the bench scenarios can show which entry should have won. Those scenarios cover duplicate matches resolved to the lowest index, entries rejected for a cleared valid bit or a single differing field, and a write racing a search at the accepting edge.

// File: rtl/ipt_pkg.sv
package ipt_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } scan_state_e;

  localparam int unsigned VALID_BIT = 0;
endpackage

// File: rtl/ipt_table_store.sv
module ipt_table_store #(
  parameter int unsigned NUM_FRAMES = 16,
  parameter int unsigned PID_W      = 8,
  parameter int unsigned VPN_W      = 20,
  parameter int unsigned CTRL_W     = 4,
  localparam int unsigned FRAME_W   = $clog2(NUM_FRAMES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [FRAME_W-1:0] wr_idx_i,
  input  logic [PID_W-1:0]   wr_pid_i,
  input  logic [VPN_W-1:0]   wr_vpn_i,
  input  logic [CTRL_W-1:0]  wr_ctrl_i,
  input  logic [FRAME_W-1:0] wr_link_i,
  input  logic [FRAME_W-1:0] scan_idx_i,
  output logic               scan_valid_o,
  output logic [PID_W-1:0]   scan_pid_o,
  output logic [VPN_W-1:0]   scan_vpn_o,
  input  logic [FRAME_W-1:0] rd_idx_i,
  output logic [PID_W-1:0]   rd_pid_o,
  output logic [VPN_W-1:0]   rd_vpn_o,
  output logic [CTRL_W-1:0]  rd_ctrl_o,
  output logic [FRAME_W-1:0] rd_link_o
);
  logic [PID_W-1:0]   pid_q  [NUM_FRAMES];
  logic [VPN_W-1:0]   vpn_q  [NUM_FRAMES];
  logic [CTRL_W-1:0]  ctrl_q [NUM_FRAMES];
  logic [FRAME_W-1:0] link_q [NUM_FRAMES];
  logic [NUM_FRAMES-1:0] valid_vec;

  for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_entry
    logic sel;
    assign sel = wr_en_i && (wr_idx_i == FRAME_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pid_q[g]  <= '0;
        vpn_q[g]  <= '0;
        ctrl_q[g] <= '0;
        link_q[g] <= '0;
      end else if (sel) begin
        pid_q[g]  <= wr_pid_i;
        vpn_q[g]  <= wr_vpn_i;
        ctrl_q[g] <= wr_ctrl_i;
        link_q[g] <= wr_link_i;
      end
    end
    assign valid_vec[g] = ctrl_q[g][ipt_pkg::VALID_BIT];
  end

  assign scan_valid_o = valid_vec[scan_idx_i];
  assign scan_pid_o   = pid_q[scan_idx_i];
  assign scan_vpn_o   = vpn_q[scan_idx_i];

  assign rd_pid_o  = pid_q[rd_idx_i];
  assign rd_vpn_o  = vpn_q[rd_idx_i];
  assign rd_ctrl_o = ctrl_q[rd_idx_i];
  assign rd_link_o = link_q[rd_idx_i];
endmodule

// File: rtl/ipt_entry_match.sv
module ipt_entry_match #(
  parameter int unsigned PID_W = 8,
  parameter int unsigned VPN_W = 20
) (
  input  logic             ent_valid_i,
  input  logic [PID_W-1:0] ent_pid_i,
  input  logic [VPN_W-1:0] ent_vpn_i,
  input  logic [PID_W-1:0] key_pid_i,
  input  logic [VPN_W-1:0] key_vpn_i,
  output logic             hit_o
);
  logic pid_eq, vpn_eq;
  assign pid_eq = (ent_pid_i == key_pid_i);
  assign vpn_eq = (ent_vpn_i == key_vpn_i);
  assign hit_o  = ent_valid_i && pid_eq && vpn_eq;
endmodule

// File: rtl/ipt_scan_ctrl.sv
module ipt_scan_ctrl #(
  parameter int unsigned NUM_FRAMES = 16,
  localparam int unsigned FRAME_W   = $clog2(NUM_FRAMES),
  localparam logic [FRAME_W-1:0] LAST_IDX = FRAME_W'(NUM_FRAMES - 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               hit_i,
  output logic               idle_o,
  output logic [FRAME_W-1:0] scan_idx_o,
  output logic               done_o,
  output logic               done_hit_o
);
  import ipt_pkg::*;

  scan_state_e        state_q;
  logic [FRAME_W-1:0] idx_q;
  logic               at_last;

  assign at_last    = (idx_q == LAST_IDX);
  assign idle_o     = (state_q == ST_IDLE);
  assign scan_idx_o = idx_q;
  assign done_o     = (state_q == ST_SCAN) && (hit_i || at_last);
  assign done_hit_o = (state_q == ST_SCAN) && hit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_SCAN;
            idx_q   <= '0;
          end
        end
        ST_SCAN: begin
          if (hit_i || at_last) state_q <= ST_IDLE;
          else                  idx_q   <= idx_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ipt_search_unit.sv
module ipt_search_unit #(
  parameter int unsigned NUM_FRAMES = 16,
  parameter int unsigned PID_W      = 8,
  parameter int unsigned VPN_W      = 20,
  parameter int unsigned OFF_W      = 12,
  parameter int unsigned CTRL_W     = 4,
  localparam int unsigned FRAME_W   = $clog2(NUM_FRAMES),
  localparam int unsigned PADDR_W   = FRAME_W + OFF_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [PID_W-1:0]   req_pid_i,
  input  logic [VPN_W-1:0]   req_vpn_i,
  input  logic [OFF_W-1:0]   req_off_i,
  input  logic               wr_en_i,
  output logic               wr_ready_o,
  input  logic [FRAME_W-1:0] wr_idx_i,
  input  logic [PID_W-1:0]   wr_pid_i,
  input  logic [VPN_W-1:0]   wr_vpn_i,
  input  logic [CTRL_W-1:0]  wr_ctrl_i,
  input  logic [FRAME_W-1:0] wr_link_i,
  input  logic [FRAME_W-1:0] rd_idx_i,
  output logic [PID_W-1:0]   rd_pid_o,
  output logic [VPN_W-1:0]   rd_vpn_o,
  output logic [CTRL_W-1:0]  rd_ctrl_o,
  output logic [FRAME_W-1:0] rd_link_o,
  output logic               rsp_valid_o,
  output logic               rsp_hit_o,
  output logic [PADDR_W-1:0] rsp_paddr_o
);
  logic               idle;
  logic               accept;
  logic               wr_take;
  logic [FRAME_W-1:0] scan_idx;
  logic               scan_valid;
  logic [PID_W-1:0]   scan_pid;
  logic [VPN_W-1:0]   scan_vpn;
  logic               ent_hit;
  logic               done, done_hit;

  logic [PID_W-1:0]   key_pid_q;
  logic [VPN_W-1:0]   key_vpn_q;
  logic [OFF_W-1:0]   key_off_q;
  logic               rsp_valid_q, rsp_hit_q;
  logic [PADDR_W-1:0] rsp_paddr_q;

  assign req_ready_o = idle;
  assign wr_ready_o  = idle;
  assign accept      = req_valid_i && idle;
  assign wr_take     = wr_en_i && idle;

  ipt_table_store #(
    .NUM_FRAMES(NUM_FRAMES), .PID_W(PID_W), .VPN_W(VPN_W), .CTRL_W(CTRL_W)
  ) u_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_take),
    .wr_idx_i     (wr_idx_i),
    .wr_pid_i     (wr_pid_i),
    .wr_vpn_i     (wr_vpn_i),
    .wr_ctrl_i    (wr_ctrl_i),
    .wr_link_i    (wr_link_i),
    .scan_idx_i   (scan_idx),
    .scan_valid_o (scan_valid),
    .scan_pid_o   (scan_pid),
    .scan_vpn_o   (scan_vpn),
    .rd_idx_i     (rd_idx_i),
    .rd_pid_o     (rd_pid_o),
    .rd_vpn_o     (rd_vpn_o),
    .rd_ctrl_o    (rd_ctrl_o),
    .rd_link_o    (rd_link_o)
  );

  ipt_entry_match #(.PID_W(PID_W), .VPN_W(VPN_W)) u_match (
    .ent_valid_i (scan_valid),
    .ent_pid_i   (scan_pid),
    .ent_vpn_i   (scan_vpn),
    .key_pid_i   (key_pid_q),
    .key_vpn_i   (key_vpn_q),
    .hit_o       (ent_hit)
  );

  ipt_scan_ctrl #(.NUM_FRAMES(NUM_FRAMES)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (accept),
    .hit_i      (ent_hit),
    .idle_o     (idle),
    .scan_idx_o (scan_idx),
    .done_o     (done),
    .done_hit_o (done_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_pid_q <= '0;
      key_vpn_q <= '0;
      key_off_q <= '0;
    end else if (accept) begin
      key_pid_q <= req_pid_i;
      key_vpn_q <= req_vpn_i;
      key_off_q <= req_off_i;
    end
  end

  // frame number is the scan position, not a stored field
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_paddr_q <= '0;
    end else begin
      rsp_valid_q <= done;
      if (done) begin
        rsp_hit_q   <= done_hit;
        rsp_paddr_q <= done_hit ? {scan_idx, key_off_q} : '0;
      end
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_hit_o   = rsp_hit_q;
  assign rsp_paddr_o = rsp_paddr_q;
endmodule

// File: rtl/ipt_search_chk.sv
module ipt_search_chk #(
  parameter int unsigned NUM_FRAMES = 16,
  parameter int unsigned PID_W      = 8,
  parameter int unsigned VPN_W      = 20,
  parameter int unsigned OFF_W      = 12,
  parameter int unsigned CTRL_W     = 4,
  localparam int unsigned FRAME_W   = $clog2(NUM_FRAMES),
  localparam int unsigned PADDR_W   = FRAME_W + OFF_W
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_valid_i,
  input logic               req_ready_o,
  input logic [OFF_W-1:0]   req_off_i,
  input logic               wr_en_i,
  input logic               wr_ready_o,
  input logic [FRAME_W-1:0] wr_idx_i,
  input logic [FRAME_W-1:0] rd_idx_i,
  input logic [PID_W-1:0]   rd_pid_o,
  input logic [VPN_W-1:0]   rd_vpn_o,
  input logic [CTRL_W-1:0]  rd_ctrl_o,
  input logic [FRAME_W-1:0] rd_link_o,
  input logic               rsp_valid_o,
  input logic               rsp_hit_o,
  input logic [PADDR_W-1:0] rsp_paddr_o
);
  logic [15:0]      edges_q;
  logic [OFF_W-1:0] off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      edges_q <= '0;
      off_q   <= '0;
    end else if (req_valid_i && req_ready_o) begin
      edges_q <= '0;
      off_q   <= req_off_i;
    end else if (edges_q != 16'hffff) begin
      edges_q <= edges_q + 1'b1;
    end
  end

  // R6
  accept_drops_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  // R8
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  // R5
  miss_zero_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_hit_o) |-> (rsp_paddr_o == '0));

  // R5
  miss_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_hit_o) |-> (edges_q == 16'(NUM_FRAMES)));

  // R4
  hit_frame_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_hit_o) |->
      (16'(rsp_paddr_o[PADDR_W-1:OFF_W]) == edges_q - 16'd1));

  // R3
  hit_offset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_hit_o) |-> (rsp_paddr_o[OFF_W-1:0] == off_q));

  // R7
  wr_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_ready_o && (rd_idx_i == wr_idx_i)) |=>
      ((rd_idx_i != $past(rd_idx_i)) ||
       ($stable(rd_pid_o) && $stable(rd_vpn_o) && $stable(rd_ctrl_o) && $stable(rd_link_o))));
endmodule

bind ipt_search_unit ipt_search_chk #(
  .NUM_FRAMES(NUM_FRAMES), .PID_W(PID_W), .VPN_W(VPN_W), .OFF_W(OFF_W), .CTRL_W(CTRL_W)
) chk_i (.*);

// File: tb/ipt_search_unit_tb_top.sv
`timescale 1ns/1ps
module ipt_search_unit_tb_top;
  localparam int N = 16, PW = 8, VW = 20, OW = 12, CW = 4, FW = 4, AW = FW + OW;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          req_valid = 0;
  logic [PW-1:0] req_pid = 0;
  logic [VW-1:0] req_vpn = 0;
  logic [OW-1:0] req_off = 0;
  logic          wr_en = 0;
  logic [FW-1:0] wr_idx = 0, wr_link = 0, rd_idx = 0;
  logic [PW-1:0] wr_pid = 0;
  logic [VW-1:0] wr_vpn = 0;
  logic [CW-1:0] wr_ctrl = 0;
  logic          req_ready, wr_ready, rsp_valid, rsp_hit;
  logic [PW-1:0] rd_pid;
  logic [VW-1:0] rd_vpn;
  logic [CW-1:0] rd_ctrl;
  logic [FW-1:0] rd_link;
  logic [AW-1:0] rsp_paddr;

  ipt_search_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_pid_i(req_pid), .req_vpn_i(req_vpn), .req_off_i(req_off),
    .wr_en_i(wr_en), .wr_ready_o(wr_ready), .wr_idx_i(wr_idx),
    .wr_pid_i(wr_pid), .wr_vpn_i(wr_vpn), .wr_ctrl_i(wr_ctrl), .wr_link_i(wr_link),
    .rd_idx_i(rd_idx), .rd_pid_o(rd_pid), .rd_vpn_o(rd_vpn),
    .rd_ctrl_o(rd_ctrl), .rd_link_o(rd_link),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_paddr_o(rsp_paddr)
  );

  int checks = 0, errors = 0;

  // reference model state
  logic [PW-1:0] m_pid [N];
  logic [VW-1:0] m_vpn [N];
  logic [CW-1:0] m_ctrl[N];
  logic [FW-1:0] m_link[N];
  bit            m_busy = 0, m_acc = 0, exp_rv = 0, exp_hit = 0, m_hit = 0;
  int            m_wait = 0;
  logic [AW-1:0] exp_pa = 0, m_pa = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_pid[i] = 0; m_vpn[i] = 0; m_ctrl[i] = 0; m_link[i] = 0;
      end
      m_busy = 0; exp_rv = 0; m_acc = 0;
    end else begin
      exp_rv = 0; m_acc = 0;
      if (m_busy) begin
        m_wait--;
        if (m_wait == 0) begin
          exp_rv = 1; exp_hit = m_hit; exp_pa = m_pa; m_busy = 0;
        end
      end else begin
        if (wr_en) begin
          m_pid[wr_idx] = wr_pid; m_vpn[wr_idx] = wr_vpn;
          m_ctrl[wr_idx] = wr_ctrl; m_link[wr_idx] = wr_link;
        end
        if (req_valid) begin
          int found;
          found = -1;
          for (int i = 0; i < N; i++)
            if (found < 0 && m_ctrl[i][0] && m_pid[i] == req_pid && m_vpn[i] == req_vpn)
              found = i;
          m_hit  = (found >= 0);
          m_pa   = m_hit ? {found[FW-1:0], req_off} : '0;
          m_wait = m_hit ? found + 1 : N;
          m_busy = 1; m_acc = 1;
        end
      end
    end
  end

  // compare on every clock, away from the edge
  always @(negedge clk) begin
    if (rst_n) begin
      check(rsp_valid == exp_rv, "R4/R5/R8 rsp_valid timing", rsp_valid, exp_rv);
      check(req_ready == !m_busy, "R6 req_ready", req_ready, !m_busy);
      check(wr_ready == !m_busy, "R7 wr_ready", wr_ready, !m_busy);
      check({rd_pid, rd_vpn, rd_ctrl, rd_link} ==
            {m_pid[rd_idx], m_vpn[rd_idx], m_ctrl[rd_idx], m_link[rd_idx]},
            "R7 read port contents", {rd_pid, rd_vpn, rd_ctrl, rd_link},
            {m_pid[rd_idx], m_vpn[rd_idx], m_ctrl[rd_idx], m_link[rd_idx]});
      if (exp_rv) begin
        check(rsp_hit == exp_hit, "R2 hit/miss", rsp_hit, exp_hit);
        check(rsp_paddr == exp_pa, "R3/R5 paddr", rsp_paddr, exp_pa);
      end
    end
  end

  task automatic write_ent(input int idx, input int pid, input int vpn, input int ctrl, input int link);
    @(negedge clk); #2;
    wr_en = 1; wr_idx = idx[FW-1:0]; wr_pid = pid[PW-1:0]; wr_vpn = vpn[VW-1:0];
    wr_ctrl = ctrl[CW-1:0]; wr_link = link[FW-1:0];
    @(negedge clk); #2;
    wr_en = 0;
  endtask

  task automatic search(input int pid, input int vpn, input int off);
    @(negedge clk); #2;
    req_valid = 1; req_pid = pid[PW-1:0]; req_vpn = vpn[VW-1:0]; req_off = off[OW-1:0];
    do @(negedge clk); while (!m_acc);
    #2 req_valid = 0;
    while (m_busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: idle, empty table
    check(req_ready && wr_ready && !rsp_valid, "R1 reset handshake", {req_ready, wr_ready, rsp_valid}, 3'b110);
    for (int i = 0; i < N; i++) begin
      rd_idx = i[FW-1:0]; #1;
      check({rd_pid, rd_vpn, rd_ctrl, rd_link} == '0, "R1 entry cleared", {rd_pid, rd_vpn, rd_ctrl, rd_link}, 0);
    end

    write_ent(0, 1, 'h100, 'h1, 3);
    write_ent(5, 2, 'h200, 'h3, 0);
    write_ent(9, 2, 'h200, 'h1, 0);
    write_ent(15, 3, 'hABC, 'h1, 7);
    write_ent(7, 4, 'h300, 'hE, 0);   // valid bit clear
    write_ent(3, 5, 'h111, 'h1, 1);

    search(1, 'h100, 'h123);   // R4 hit at index 0
    search(2, 'h200, 'hFFF);   // R4 duplicate: lowest index 5 wins
    search(3, 'hABC, 'h000);   // R3 hit at last index
    search(4, 'h300, 'h055);   // R2 invalid entry never matches
    search(5, 'h100, 'h001);   // R2 pid agrees elsewhere, vpn differs
    search(1, 'h111, 'h002);   // R2 vpn agrees, pid differs
    search(9, 'h999, 'h003);   // R5 plain miss

    // R7: write during a search is refused
    rd_idx = 2;
    fork
      search(3, 'hABC, 'h444);
      begin
        repeat (4) @(negedge clk);
        #2 wr_en = 1; wr_idx = 2; wr_pid = 3; wr_vpn = 'hABC; wr_ctrl = 1; wr_link = 5;
        repeat (3) @(negedge clk);
        #2 wr_en = 0;
      end
    join
    check(rd_ctrl == 0, "R7 blocked write left entry 2", rd_ctrl, 0);

    // R7: write and request at the same edge; search sees new entry 1
    @(negedge clk); #2;
    wr_en = 1; wr_idx = 1; wr_pid = 6; wr_vpn = 'h600; wr_ctrl = 1; wr_link = 2;
    req_valid = 1; req_pid = 6; req_vpn = 'h600; req_off = 'h0AA;
    @(negedge clk); #2;
    wr_en = 0; req_valid = 0;
    while (m_busy) @(negedge clk);
    @(negedge clk);

    // R8/R6: request held high, back-to-back searches, changed fields ignored while busy
    @(negedge clk); #2;
    req_valid = 1; req_pid = 2; req_vpn = 'h200; req_off = 'h321;
    repeat (9) @(negedge clk);
    #2 req_pid = 9; req_vpn = 'h999;
    repeat (40) @(negedge clk);
    #2 req_valid = 0;
    while (m_busy) @(negedge clk);
    repeat (3) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule